// File: doc/BRIEF.md
# Rotate-Mask Flag Insertion Unit

This unit decodes and executes one 32-bit instruction. The instruction rotates a 64-bit general-purpose register value to the right by an immediate amount. It then copies the lowest four bits of the rotated value into the N, Z, C and V condition flags. A 4-bit immediate acts as a write mask, so each flag is either replaced or kept. The unit holds the four flags in its own register and shows them on an output.

Each cycle, the pipeline presents an instruction word together with a valid strobe. The unit drives the source-register index straight from the word, and the register file returns the 64-bit value in the same cycle. On the next clock edge the unit updates the flags and raises a completion pulse. If the instruction-set feature is disabled, the unit raises an undefined-instruction pulse instead. A word that does not carry this encoding is ignored. The work takes the same single cycle whatever the register value, the rotate amount or the mask.

Top module: `flag_insert_unit`

## Requirements
- R1: A word is accepted as this instruction only when bits 31..21 equal 10111010000, bits 14..10 equal 00001 and bit 4 equals 0. Valid is high, and the feature enable is high, so the completion pulse rises in the next cycle.
- R2: The rotate amount is taken from bits 20..15 (0 to 63), the source index from bits 9..5 and the flag mask from bits 3..0. The source index appears on `src_idx` in the same cycle.
- R3: The inserted nibble is the source value rotated right by the amount, low 4 bits. This equals bits [amount+3:amount] of the value concatenated with itself, so amounts above 60 wrap around into bits 0..2.
- R4: Nibble bit 3 is written to N (`nzcv[3]`), bit 2 to Z (`nzcv[2]`), bit 1 to C (`nzcv[1]`) and bit 0 to V (`nzcv[0]`).
- R5: Mask bit k enables the write of `nzcv[k]`. A flag whose mask bit is 0 keeps its previous value.
- R6: When a matching word arrives with the feature enable low, `undef` pulses in the next cycle, `done` stays low and no flag changes.
- R7: Flags and `done` change exactly one cycle after acceptance, for any data, amount or mask. Each pulse lasts one cycle. The read data is sampled in the acceptance cycle. `done` and `undef` are never high together.
- R8: Source index 31 reads as zero, so every enabled flag is written with 0.
- R9: A word that does not match, or a cycle with valid low, produces neither pulse and leaves the flags unchanged.
- R10: Synchronous reset sets `nzcv` to 0000 and clears `done` and `undef`.
- R11: A mask of 0000 still produces `done` but changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word is present this cycle |
| insn_word | input | 32 | Instruction word |
| feat_en | input | 1 | Instruction-set feature enabled |
| src_idx | output | 5 | Source register index to the register file |
| src_data | input | 64 | Register read data for `src_idx`, same cycle |
| nzcv | output | 4 | Condition flags N,Z,C,V (bits 3..0) |
| done | output | 1 | Completion pulse, one cycle |
| undef | output | 1 | Undefined-instruction pulse, one cycle |

## Verification
Two things can land in the same cycle: the flag update of one instruction and the acceptance of the next. In that cycle the second instruction's partial mask must merge into flags that were only just written. The bench provokes this by holding valid high for several consecutive words, with overlapping and disjoint masks. After each edge it compares `nzcv`, `done` and `undef` with a bench model that applies every instruction in turn. A reset is also driven while an instruction is valid, to check that reset wins.

// File: rtl/fi_pkg.sv
package fi_pkg;
  localparam int WORD_W  = 32;
  localparam int DATA_W  = 64;
  localparam int FLAG_W  = 4;
  localparam int IDX_W   = 5;
  localparam int AMT_W   = $clog2(DATA_W);

  localparam logic [10:0] OPC_TOP = 11'b10111010000;
  localparam logic [4:0]  OPC_MID = 5'b00001;

  typedef struct packed {
    logic               match;
    logic [AMT_W-1:0]   amt;
    logic [IDX_W-1:0]   idx;
    logic [FLAG_W-1:0]  mask;
  } fi_dec_t;
endpackage

// File: rtl/fi_decoder.sv
module fi_decoder
  import fi_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output fi_dec_t           dec
);
  logic top_ok, mid_ok, low_ok;

  always_comb begin
    top_ok    = (word[31:21] == OPC_TOP);
    mid_ok    = (word[14:10] == OPC_MID);
    low_ok    = (word[4] == 1'b0);
    dec.match = top_ok & mid_ok & low_ok;
    dec.amt   = word[15 +: AMT_W];
    dec.idx   = word[5 +: IDX_W];
    dec.mask  = word[0 +: FLAG_W];
  end
endmodule

// File: rtl/fi_rotator.sv
module fi_rotator #(
  parameter int DATA_W = 64,
  parameter int OUT_W  = 4,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  output logic [OUT_W-1:0]  dout
);
  logic [DATA_W-1:0] stg [SH_W+1];

  assign stg[0] = din;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int STEP = 2 ** s;
    logic [DATA_W-1:0] rot;
    assign rot        = {stg[s][STEP-1:0], stg[s][DATA_W-1:STEP]};
    assign stg[s + 1] = amt[s] ? rot : stg[s];
  end

  assign dout = stg[SH_W][OUT_W-1:0];
endmodule

// File: rtl/fi_flag_reg.sv
module fi_flag_reg #(
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_mask,
  input  logic [FLAG_W-1:0] wr_val,
  output logic [FLAG_W-1:0] flags
);
  for (genvar k = 0; k < FLAG_W; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        flags[k] <= 1'b0;
      else if (wr_en && wr_mask[k])
        flags[k] <= wr_val[k];
    end
  end
endmodule

// File: rtl/flag_insert_unit.sv
module flag_insert_unit
  import fi_pkg::*;
#(
  parameter int ZERO_IDX = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_valid,
  input  logic [WORD_W-1:0] insn_word,
  input  logic              feat_en,
  output logic [IDX_W-1:0]  src_idx,
  input  logic [DATA_W-1:0] src_data,
  output logic [FLAG_W-1:0] nzcv,
  output logic              done,
  output logic              undef
);
  fi_dec_t           dec;
  logic              accept, exec, reads_zero;
  logic [DATA_W-1:0] operand;
  logic [FLAG_W-1:0] nib;

  fi_decoder u_dec (.word(insn_word), .dec(dec));

  assign src_idx    = dec.idx;
  assign accept     = insn_valid & dec.match;
  assign exec       = accept & feat_en;
  assign reads_zero = (dec.idx == IDX_W'(ZERO_IDX));
  assign operand    = reads_zero ? '0 : src_data;

  fi_rotator #(.DATA_W(DATA_W), .OUT_W(FLAG_W)) u_rot (
    .din (operand),
    .amt (dec.amt),
    .dout(nib)
  );

  fi_flag_reg #(.FLAG_W(FLAG_W)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (exec),
    .wr_mask(dec.mask),
    .wr_val (nib),
    .flags  (nzcv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      undef <= 1'b0;
    end else begin
      done  <= exec;
      undef <= accept & ~feat_en;
    end
  end
endmodule

// File: rtl/fi_checker.sv
module fi_checker
  import fi_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              insn_valid,
  input logic [WORD_W-1:0] insn_word,
  input logic              feat_en,
  input logic [FLAG_W-1:0] nzcv,
  input logic              done,
  input logic              undef
);
  logic hit;
  assign hit = insn_valid && (insn_word[31:21] == 11'h5D0) &&
               (insn_word[14:10] == 5'd1) && !insn_word[4];

  assert_exec_done_R1: assert property (@(posedge clk) disable iff (rst)
    hit && feat_en |=> done && !undef);

  assert_mask_keep_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (((nzcv ^ $past(nzcv)) & ~$past(insn_word[3:0])) == 4'b0));

  assert_undef_hold_R6: assert property (@(posedge clk) disable iff (rst)
    undef |-> (nzcv == $past(nzcv)) && !done);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(insn_valid) |-> !done && !undef);

  assert_zero_src_R8: assert property (@(posedge clk) disable iff (rst)
    done && ($past(insn_word[9:5]) == 5'd31) |-> ((nzcv & $past(insn_word[3:0])) == 4'b0));

  assert_nomatch_R9: assert property (@(posedge clk) disable iff (rst)
    insn_valid && !hit |=> !done && !undef && $stable(nzcv));

  assert_reset_R10: assert property (@(posedge clk)
    $past(rst) |-> (nzcv == 4'b0) && !done && !undef);
endmodule

bind flag_insert_unit fi_checker chk_i (
  .clk       (clk),
  .rst       (rst),
  .insn_valid(insn_valid),
  .insn_word (insn_word),
  .feat_en   (feat_en),
  .nzcv      (nzcv),
  .done      (done),
  .undef     (undef)
);

// File: tb/flag_insert_unit_tb_top.sv
module flag_insert_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_valid = 1'b0;
  logic [31:0] insn_word = '0;
  logic        feat_en = 1'b1;
  logic [4:0]  src_idx;
  logic [63:0] src_data = '0;
  logic [3:0]  nzcv;
  logic        done, undef;

  int n_run = 0;
  int n_fail = 0;

  logic [3:0] m_nzcv = 4'b0;
  logic       m_done = 1'b0;
  logic       m_undef = 1'b0;

  always #4 clk = ~clk;

  flag_insert_unit dut_i (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
    .feat_en(feat_en), .src_idx(src_idx), .src_data(src_data),
    .nzcv(nzcv), .done(done), .undef(undef)
  );

  function automatic logic [31:0] mk(input int amt, input int idx, input int msk);
    mk = 32'hBA000400 | (32'(amt) << 15) | (32'(idx) << 5) | 32'(msk);
  endfunction

  typedef struct packed {
    logic [31:0] word;
    logic [63:0] data;
    logic        feat;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{mk(0, 1, 15),  64'h0000_0000_0000_000A, 1'b1},  // R3 R4 amount 0
    '{mk(4, 2, 15),  64'h0000_0000_0000_0050, 1'b1},  // R3 amount 4
    '{mk(62, 3, 15), 64'h8000_0000_0000_0001, 1'b1},  // R3 wrap
    '{mk(63, 4, 15), 64'h8000_0000_0000_0005, 1'b1},  // R3 wrap
    '{mk(60, 5, 15), 64'hC000_0000_0000_0000, 1'b1},  // R3 top nibble
    '{mk(32, 6, 15), 64'h0000_0009_0000_0000, 1'b1},  // R3 middle
    '{mk(0, 7, 8),   64'h0000_0000_0000_0000, 1'b1},  // R5 only N
    '{mk(0, 8, 3),   64'h0000_0000_0000_000F, 1'b1},  // R5 only C,V
    '{mk(0, 9, 0),   64'h0000_0000_0000_0000, 1'b1},  // R11 empty mask
    '{mk(0, 10, 15), 64'h0000_0000_0000_0000, 1'b0},  // R6 feature off
    '{mk(0, 1, 15) | 32'h10,       64'h0, 1'b1},      // R9 bit 4 set
    '{mk(0, 1, 15) ^ 32'h0020_0000, 64'h0, 1'b1},     // R9 bit 21 flipped
    '{mk(0, 1, 15) ^ 32'h0000_0800, 64'h0, 1'b1},     // R9 bit 11 flipped
    '{mk(1, 31, 15), 64'hFFFF_FFFF_FFFF_FFFF, 1'b1}   // R8 index 31
  };

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // bench model, written from the requirements
  task automatic model(input logic v, input logic [31:0] w, input logic [63:0] d, input logic f);
    logic         m;
    logic [127:0] dd;
    logic [3:0]   nb;
    m  = v && (w[31:21] == 11'b10111010000) && (w[14:10] == 5'b00001) && !w[4];
    dd = (w[9:5] == 5'd31) ? 128'd0 : {d, d};
    dd = dd >> w[20:15];
    nb = dd[3:0];
    m_done  = m && f;
    m_undef = m && !f;
    if (m && f)
      m_nzcv = (m_nzcv & ~w[3:0]) | (nb & w[3:0]);
  endtask

  task automatic step(input string req, input logic v, input logic [31:0] w,
                      input logic [63:0] d, input logic f);
    insn_valid = v;
    insn_word  = w;
    src_data   = d;
    feat_en    = f;
    #1;
    if (v) check({req, " R2 src_idx"}, 64'(src_idx), 64'(w[9:5]));
    @(posedge clk);
    #1;
    src_data = 64'hDEAD_BEEF_0BAD_F00D;  // R7: later data must not matter
    @(negedge clk);
    model(v, w, d, f);
    check({req, " nzcv"}, 64'(nzcv), 64'(m_nzcv));
    check({req, " done"}, 64'(done), 64'(m_done));
    check({req, " undef"}, 64'(undef), 64'(m_undef));
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 nzcv", 64'(nzcv), 64'h0);
    check("R10 done", 64'(done), 64'h0);
    check("R10 undef", 64'(undef), 64'h0);

    for (int i = 0; i < NV; i++) begin
      step("R1/R3/R4 vector", 1'b1, VEC[i].word, VEC[i].data, VEC[i].feat);
      step("R7/R9 idle", 1'b0, VEC[i].word, VEC[i].data, VEC[i].feat);
    end

    // R9: valid low with a matching word
    step("R9 valid low", 1'b0, mk(0, 1, 15), 64'hF, 1'b1);

    // back-to-back with partial masks (R5, R7)
    step("R5 b2b a", 1'b1, mk(0, 2, 12), 64'hF, 1'b1);
    step("R5 b2b b", 1'b1, mk(0, 3, 3),  64'h5, 1'b1);
    step("R5 b2b c", 1'b1, mk(1, 4, 6),  64'h0, 1'b1);
    step("R6 b2b undef", 1'b1, mk(0, 4, 15), 64'h0, 1'b0);
    step("R7 b2b end", 1'b0, 32'h0, 64'h0, 1'b1);

    // R10: reset wins over a valid instruction
    step("R10 prep", 1'b1, mk(0, 5, 15), 64'hF, 1'b1);
    insn_valid = 1'b1;
    insn_word  = mk(0, 5, 15);
    src_data   = 64'h0;
    rst        = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst        = 1'b0;
    insn_valid = 1'b0;
    m_nzcv = 4'b0;
    check("R10 nzcv after reset", 64'(nzcv), 64'h0);
    check("R10 done after reset", 64'(done), 64'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule